// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an active-low system reset line stays asserted. It lets firmware tell a brief reset from a deliberate long press, which it can treat as a request for a factory reset. The block runs on a 25 MHz reference clock, so each count is 40 ns. The reset line passes through a two-flop synchroniser. A saturating counter then advances once per clock while the synchronised line is low.

The count survives the reset it measures. It is cleared only by the block's own power-on reset or by a software clear. This lets firmware read the press length after the line has come back high. The same small register port also carries a soft-reset control. One register holds an output-enable bit. A second, write-only register fires a fixed-length soft-reset pulse, but only when that enable bit is set.

Top module: `rst_hold_meter`

## Requirements
- R1: After power-on reset the count is 0, the enable bit is 0, `softRstOut` is low, and every register address reads 0.
- R2: `sysRstN` passes through two synchroniser flops. Holding it low for L clock edges leaves the count at exactly L once the line is released and the pipeline has settled.
- R3: The count saturates at 2^CNT_W-1 (29 bits by default) and stays there while the input remains low.
- R4: Once the input returns high, the count holds its value until it is cleared.
- R5: A write to address 0 with data bit 31 set clears the count to 0. A clear wins over an increment in the same cycle. A write to address 0 with bit 31 clear has no effect on the count.
- R6: A read of address 0 returns the count in bits CNT_W-1:0, and all higher bits read 0.
- R7: Address 1 holds the soft-reset enable in data bit 2, which reads back at bit 2. All other bits of address 1 read 0, and addresses 2 and 3 read 0.
- R8: A write to address 2 with data bit 0 set, while the enable bit is 1, drives `softRstOut` high for exactly PULSE_LEN clocks, starting in the cycle after the write.
- R9: A trigger write has no effect when the enable bit is 0, when data bit 0 is 0, or while a pulse is already running. In the last case the running pulse is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| sysRstN | input | 1 | Asynchronous system reset line being measured, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 count, 1 enable, 2 trigger) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| softRstOut | output | 1 | Soft system reset pulse, active high |

## Verification
The checker tests several properties on every cycle:
- the count never moves by more than one step per clock;
- it stays pinned at its maximum;
- it is frozen while the synchronised input is high;
- a clear takes effect on the next edge;
- unused read bits stay zero;
- a pulse rises only when enabled and never runs longer than PULSE_LEN.

The exact relation between the hold length and the final count needs the bench's scenarios, because it depends on the synchroniser latency. The same holds for the exact pulse length, and for a retrigger leaving a running pulse unchanged. To cover these, the bench sweeps every hold length from 0 past the saturation point of a 5-bit counter.

// File: rtl/rst_hold_pkg.sv
package rst_hold_pkg;
  typedef struct packed {
    logic cntInc;
    logic cntClr;
  } cntStrobes_t;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_TRIGGER = 2'd2;
  localparam int CLR_BIT = 31;
  localparam int EN_BIT = 2;
  localparam int TRIG_BIT = 0;
endpackage

// File: rtl/rst_hold_sync.sv
module rst_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic porRstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= asyncIn;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rst_hold_ctrl.sv
module rst_hold_ctrl
  import rst_hold_pkg::*;
#(
  parameter int PULSE_LEN = 8,
  localparam int PW = $clog2(PULSE_LEN + 1)
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        syncLow,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic        wrClrBit,
  input  logic        wrEnBit,
  input  logic        wrTrigBit,
  output cntStrobes_t strobes,
  output logic        maskBit,
  output logic        softRstOut
);
  logic [PW-1:0] pulseCnt;
  logic          trigReq;

  assign strobes.cntClr = regWrEn && (regAddr == ADDR_COUNT) && wrClrBit;
  assign strobes.cntInc = syncLow;
  assign trigReq = regWrEn && (regAddr == ADDR_TRIGGER) && wrTrigBit
                   && maskBit && (pulseCnt == '0);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) maskBit <= 1'b0;
    else if (regWrEn && regAddr == ADDR_ENABLE) maskBit <= wrEnBit;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) pulseCnt <= '0;
    else if (trigReq) pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign softRstOut = (pulseCnt != '0);
endmodule

// File: rtl/rst_hold_datapath.sv
module rst_hold_datapath
  import rst_hold_pkg::*;
#(
  parameter int CNT_W = 29,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             porRstN,
  input  cntStrobes_t      strobes,
  input  logic             maskBit,
  input  logic [1:0]       regAddr,
  output logic [CNT_W-1:0] countVal,
  output logic [31:0]      regRdData
);
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) countVal <= '0;
    else if (strobes.cntClr) countVal <= '0;
    else if (strobes.cntInc && countVal != CNT_MAX) countVal <= countVal + 1'b1;
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_COUNT:  regRdData[CNT_W-1:0] = countVal;
      ADDR_ENABLE: regRdData[EN_BIT] = maskBit;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rst_hold_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int PULSE_LEN = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        softRstOut
);
  logic             syncHigh;
  logic             syncLow;
  logic             maskBit;
  cntStrobes_t      strobes;
  logic [CNT_W-1:0] countVal;

  rst_hold_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .porRstN(porRstN), .asyncIn(sysRstN), .syncOut(syncHigh)
  );
  assign syncLow = ~syncHigh;

  rst_hold_ctrl #(.PULSE_LEN(PULSE_LEN)) uCtrl (
    .clk(clk), .porRstN(porRstN), .syncLow(syncLow),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .wrClrBit(regWrData[CLR_BIT]), .wrEnBit(regWrData[EN_BIT]),
    .wrTrigBit(regWrData[TRIG_BIT]),
    .strobes(strobes), .maskBit(maskBit), .softRstOut(softRstOut)
  );

  rst_hold_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .porRstN(porRstN), .strobes(strobes), .maskBit(maskBit),
    .regAddr(regAddr), .countVal(countVal), .regRdData(regRdData)
  );
endmodule

// File: rtl/rst_hold_meter_chk.sv
module rst_hold_meter_chk #(
  parameter int CNT_W = 29,
  parameter int PULSE_LEN = 8
) (
  input logic             clk,
  input logic             porRstN,
  input logic [CNT_W-1:0] countVal,
  input logic             cntClr,
  input logic             syncLow,
  input logic             maskBit,
  input logic             softRstOut,
  input logic [1:0]       regAddr,
  input logic [31:0]      regRdData
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam int RW = $clog2(PULSE_LEN + 2);
  logic [RW-1:0] runLen;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !cntClr |=> (countVal == $past(countVal)) || (countVal == $past(countVal) + 1'b1));

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (countVal == MAXV) && !cntClr |=> countVal == MAXV);

  // R4
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !syncLow && !cntClr |=> $stable(countVal));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!porRstN)
    cntClr |=> countVal == '0);

  // R9
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(softRstOut) |-> $past(maskBit));

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) runLen <= '0;
    else if (softRstOut) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  always_comb begin
    if (porRstN) begin
      // R8
      pulse_len_chk: assert (runLen <= RW'(PULSE_LEN));
      // R6
      if (regAddr == 2'd0 && CNT_W < 32)
        upper_zero_chk: assert (regRdData[31:CNT_W] == '0);
    end
  end
endmodule

bind rst_hold_meter rst_hold_meter_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) uChk (
  .clk(clk), .porRstN(porRstN), .countVal(countVal), .cntClr(strobes.cntClr),
  .syncLow(syncLow), .maskBit(maskBit), .softRstOut(softRstOut),
  .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/sim_rst_hold_meter.sv
`timescale 1ns/1ps
module sim_rst_hold_meter;
  localparam int CW = 5;
  localparam int PL = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, porRstN = 0, sysRstN = 1, regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic softRstOut;
  int nChk = 0, nFail = 0;
  int highCnt;

  always #2 clk = ~clk;

  rst_hold_meter #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .softRstOut(softRstOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #0.5; d = regRdData;
  endtask

  task automatic countPulse(input int win);
    highCnt = 0;
    for (int i = 0; i < win; i++) begin
      if (softRstOut) highCnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    cyc(3); porRstN = 1; cyc(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 read", d, 0); end
    chk("R1 pulse", {31'b0, softRstOut}, 0);

    // R2 R3 R4 R6: sweep hold lengths past saturation
    for (int L = 0; L <= 40; L++) begin
      wr(2'd0, 32'h8000_0000);
      sysRstN = 0; cyc(L); sysRstN = 1; cyc(4);
      rd(2'd0, d);
      chk((L > MAXC) ? "R3 saturate" : "R2 hold length", d, (L > MAXC) ? MAXC : L);
      cyc(6); rd(2'd0, d);
      chk("R4 held after release", d, (L > MAXC) ? MAXC : L);
    end
    chk("R6 upper bits", {27'b0, d[31:CW]}, 0);

    // R5 write without bit31 ignored
    wr(2'd0, 32'h7FFF_FFFF); rd(2'd0, d); chk("R5 no clear", d, MAXC);
    // R5 clear while held low wins then counting resumes
    sysRstN = 0; cyc(40);
    rd(2'd0, d); chk("R3 saturate low", d, MAXC);
    wr(2'd0, 32'h8000_0000); rd(2'd0, d); chk("R5 clear", d, 0);
    cyc(5); rd(2'd0, d); chk("R5 resume", d, 5);
    sysRstN = 1; cyc(4);

    // R7 enable register
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R7 enable", d, 32'h4);
    rd(2'd2, d); chk("R7 trigger reads 0", d, 0);
    rd(2'd3, d); chk("R7 addr3 reads 0", d, 0);

    // R8 pulse length
    wr(2'd2, 32'h1);
    chk("R8 pulse starts", {31'b0, softRstOut}, 1);
    countPulse(20); chk("R8 length", highCnt, PL);

    // R9 retrigger while active does not extend
    wr(2'd2, 32'h1); cyc(2); wr(2'd2, 32'h1);
    countPulse(20); chk("R9 no extend", highCnt, PL - 3);
    // R9 bit0 clear
    wr(2'd2, 32'hFFFF_FFFE); countPulse(12); chk("R9 bit0 zero", highCnt, 0);
    // R9 enable clear
    wr(2'd1, 32'h0); rd(2'd1, d); chk("R7 enable off", d, 0);
    wr(2'd2, 32'h1); countPulse(12); chk("R9 disabled", highCnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule